// File: doc/BRIEF.md
# Half-Duplex Transmit Retry Controller

This block steers one outgoing Ethernet frame through the shared-medium rules of a half-duplex MII link. After a start request it waits for the carrier to go quiet, then grants transmission to the datapath. While the frame is on the wire it watches the collision input and the datapath's byte position. An early collision leads to a retry, either after a random back-off, after carrier deferral only, or at once. A late collision, too many collisions, or a deferral that runs too long ends the frame with an abort.

The datapath supplies a timing tick at the line's symbol rate: once per nibble time at 100 Mb/s and once per bit time at 10 Mb/s. The speed input chooses the deferral limit and the slot length to match. Configuration arrives on static inputs. When the frame finishes, a one-cycle done strobe presents a packed 16-bit status word, and the block hands ownership back.

Top module: `hdx_retry_ctrl`

## Requirements
- R1: After reset `done_o`, `tx_go_o` and `own_o` are 0 and `status_o` is 0.
- R2: A start request raises `own_o` the next cycle and passes through at least one deferral cycle with `tx_go_o` low. `tx_go_o` rises once the carrier is seen low. Status bit 8 (deferred) is set when the carrier was seen high during deferral.
- R3: When `tx_end_i` is seen while `tx_go_o` is high, `done_o` pulses on the next cycle. Outside that pulse `status_o` is 0. In the word, bits 3:0 hold the collision count saturated at 15, bit 14 (abort) is clear for a completed frame, and bits 6 and 12:9 are always 0.
- R4: A collision at a byte position below the 6-bit late window is early and is retried. A collision at or above the window is late: the frame ends with no retry, with bits 5 and 14 set.
- R5: When an early collision brings the count above the 4-bit retry limit, the frame ends with bits 4 and 14 set and the count in bits 3:0.
- R6: With neither retry mode selected, the next grant follows the collision cycle by 3 + k·S cycles (tick every cycle). S is 128 ticks at 100 Mb/s and 512 at 10 Mb/s by default, and k lies in 0 .. 2^min(n,10)−1, where n is the collision count.
- R7: With the no-back-off mode, the retry skips the back-off but still defers to carrier. The grant comes 2 cycles after the collision cycle, or later if the carrier is high.
- R8: With the immediate mode, which takes precedence over no-back-off, the grant returns exactly 2 cycles after the collision cycle whatever the carrier does. Every collision drops `tx_go_o` the following cycle.
- R9: Carrier-high deferral longer than 6071 ticks at 100 Mb/s, or longer than 24287 ticks at 10 Mb/s, ends the frame with bits 7, 8 and 14 set.
- R10: With indefinite deferral selected, no deferral length ends the frame.
- R11: Status bit 13 is set when `bp_i` was high in any cycle while the block owned the frame.
- R12: A collision indication while the frame is not being transmitted has no effect on the count or the outcome.
- R13: `done_o` lasts exactly one cycle. During it, `own_o` and status bit 15 (ownership) are 0. The block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send one frame (taken in idle) |
| carrier_i | input | 1 | Carrier sense from the PHY |
| coll_i | input | 1 | Collision indication from the PHY |
| tx_end_i | input | 1 | Datapath finished sending the frame |
| tick_i | input | 1 | One pulse per nibble time (100 Mb/s) or bit time (10 Mb/s) |
| byte_cnt_i | input | CNT_W | Bytes sent since frame start |
| bp_i | input | 1 | Back-pressure being applied |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| late_win_i | input | WIN_W | Byte position where collisions become late |
| retry_lim_i | input | LIM_W | Number of retransmissions allowed |
| no_backoff_i | input | 1 | Retry without back-off, still deferring |
| immed_i | input | 1 | Retry at once, ignoring carrier |
| defer_forever_i | input | 1 | Disable the excessive-deferral abort |
| tx_go_o | output | 1 | Grant: datapath may transmit |
| own_o | output | 1 | Block owns the frame |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 16 | Completion status word, valid with done_o |

## Verification
The hardest conditions to reach from the ports are the deferral limits and the top of the collision count. The deferral limits need thousands of consecutive carrier-high ticks. Reaching a count of 16 needs that many retries without the back-off wait growing. Directed frames hold the carrier high just below and well past each speed's limit. They also drive sixteen collisions in no-back-off mode so that the count saturates and the retry limit trips. The random back-off value cannot be predicted from outside, so the bench measures the gap from each collision to the next grant. It checks that the gap is a whole number of slots within the allowed range, and it runs with a short slot length so that many retries fit.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEFER,
      ST_SEND,
      ST_RESUME,
      ST_BACKOFF,
      ST_DONE
   } hdx_state_e;

   localparam int SB_MAXCOL = 4;
   localparam int SB_LATE   = 5;
   localparam int SB_XDEF   = 7;
   localparam int SB_DEFD   = 8;
   localparam int SB_BP     = 13;
   localparam int SB_ABORT  = 14;
   localparam int SB_OWN    = 15;

endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
   parameter int W     = 16,
   parameter int OUT_W = 10,
   parameter int SEED  = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd_o
);
   logic [W-1:0] taps;
   logic [W-1:0] s_q;

   if (OUT_W > W) begin : g_bad_out
      $error("hdx_lfsr: OUT_W wider than W");
   end
   if (W'(SEED) == '0) begin : g_bad_seed
      $error("hdx_lfsr: seed must be nonzero");
   end

   if (W == 16) begin : g_t16
      assign taps = W'(32'h0000_B400);
   end else if (W == 24) begin : g_t24
      assign taps = W'(32'h00E1_0000);
   end else if (W == 32) begin : g_t32
      assign taps = W'(32'h8020_0003);
   end else begin : g_tbad
      assign taps = '0;
      $error("hdx_lfsr: unsupported width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       s_q <= W'(SEED);
      else if (s_q[0])  s_q <= (s_q >> 1) ^ taps;
      else              s_q <= s_q >> 1;
   end

   assign rnd_o = s_q[OUT_W-1:0];
endmodule

// File: rtl/hdx_defer_timer.sv
module hdx_defer_timer #(
   parameter int NIB_LIM = 6071,
   parameter int BIT_LIM = 24287
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   input  logic speed100_i,
   output logic over_o
);
   localparam int LIM_MAX = (NIB_LIM > BIT_LIM) ? NIB_LIM : BIT_LIM;
   localparam int CW      = $clog2(LIM_MAX + 2);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim = speed100_i ? CW'(NIB_LIM) : CW'(BIT_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr_i)                 cnt_q <= '0;
      else if (run_i && cnt_q <= lim) cnt_q <= cnt_q + 1'b1;
   end

   assign over_o = cnt_q > lim;
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff #(
   parameter int SLOT_NIB = 128,
   parameter int SLOT_BIT = 512,
   parameter int SW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [SW-1:0] slots_i,
   input  logic          speed100_i,
   input  logic          tick_i,
   output logic          expired_o
);
   localparam int SLOT_MAX = (SLOT_NIB > SLOT_BIT) ? SLOT_NIB : SLOT_BIT;
   localparam int TW       = $clog2(SLOT_MAX);

   if (SLOT_NIB < 2 || SLOT_BIT < 2) begin : g_bad_slot
      $error("hdx_backoff: slot length must be at least 2 ticks");
   end

   logic [SW-1:0] left_q;
   logic [TW-1:0] tcnt_q;
   logic [TW-1:0] slot_end;

   assign slot_end = speed100_i ? TW'(SLOT_NIB - 1) : TW'(SLOT_BIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         tcnt_q <= '0;
      end else if (load_i) begin
         left_q <= slots_i;
         tcnt_q <= '0;
      end else if (left_q != '0 && tick_i) begin
         if (tcnt_q == slot_end) begin
            tcnt_q <= '0;
            left_q <= left_q - 1'b1;
         end else begin
            tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   assign expired_o = (left_q == '0);
endmodule

// File: rtl/hdx_retry_ctrl.sv
module hdx_retry_ctrl
   import hdx_pkg::*;
#(
   parameter int CNT_W         = 11,
   parameter int WIN_W         = 6,
   parameter int LIM_W         = 4,
   parameter int NIB_DEFER_LIM = 6071,
   parameter int BIT_DEFER_LIM = 24287,
   parameter int SLOT_NIB      = 128,
   parameter int SLOT_BIT      = 512,
   parameter int BO_CAP        = 10,
   parameter int LFSR_W        = 16,
   parameter int LFSR_SEED     = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             carrier_i,
   input  logic             coll_i,
   input  logic             tx_end_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] byte_cnt_i,
   input  logic             bp_i,
   input  logic             speed100_i,
   input  logic [WIN_W-1:0] late_win_i,
   input  logic [LIM_W-1:0] retry_lim_i,
   input  logic             no_backoff_i,
   input  logic             immed_i,
   input  logic             defer_forever_i,
   output logic             tx_go_o,
   output logic             own_o,
   output logic             done_o,
   output logic [15:0]      status_o
);
   localparam int CC_W = LIM_W + 1;

   if (WIN_W > CNT_W) begin : g_bad_win
      $error("hdx_retry_ctrl: late window wider than byte counter");
   end
   if (LIM_W < 1 || LIM_W > 8) begin : g_bad_lim
      $error("hdx_retry_ctrl: LIM_W out of range");
   end
   if (BO_CAP < 1 || BO_CAP > LFSR_W) begin : g_bad_cap
      $error("hdx_retry_ctrl: back-off cap exceeds random source");
   end

   hdx_state_e         state_q;
   logic [CC_W-1:0]    coll_cnt_q, cnt_nxt;
   logic               late_q, maxc_q, xdef_q, defd_q, bp_q;
   logic               late_hit, over_lim, defer_over, bo_expired, bo_load;
   logic [BO_CAP-1:0]  rnd, bo_mask, bo_slots;
   logic [3:0]         cnt_field;

   assign cnt_nxt  = coll_cnt_q + 1'b1;
   assign late_hit = byte_cnt_i >= CNT_W'(late_win_i);
   assign over_lim = cnt_nxt > {1'b0, retry_lim_i};

   always_comb begin
      for (int i = 0; i < BO_CAP; i++) bo_mask[i] = (int'(cnt_nxt) > i);
   end
   assign bo_slots = rnd & bo_mask;
   assign bo_load  = (state_q == ST_SEND) && coll_i && !late_hit && !over_lim
                     && !immed_i && !no_backoff_i;

   hdx_lfsr #(.W(LFSR_W), .OUT_W(BO_CAP), .SEED(LFSR_SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .rnd_o(rnd));

   hdx_defer_timer #(.NIB_LIM(NIB_DEFER_LIM), .BIT_LIM(BIT_DEFER_LIM)) u_defer (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q == ST_IDLE),
      .run_i((state_q == ST_DEFER) && carrier_i && tick_i),
      .speed100_i(speed100_i), .over_o(defer_over));

   hdx_backoff #(.SLOT_NIB(SLOT_NIB), .SLOT_BIT(SLOT_BIT), .SW(BO_CAP)) u_bo (
      .clk(clk), .rst_n(rst_n), .load_i(bo_load), .slots_i(bo_slots),
      .speed100_i(speed100_i), .tick_i(tick_i), .expired_o(bo_expired));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         coll_cnt_q <= '0;
         late_q     <= 1'b0;
         maxc_q     <= 1'b0;
         xdef_q     <= 1'b0;
         defd_q     <= 1'b0;
         bp_q       <= 1'b0;
      end else begin
         if (own_o && bp_i) bp_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q    <= ST_DEFER;
               coll_cnt_q <= '0;
               late_q     <= 1'b0;
               maxc_q     <= 1'b0;
               xdef_q     <= 1'b0;
               defd_q     <= 1'b0;
               bp_q       <= 1'b0;
            end
            ST_DEFER: begin
               if (carrier_i) defd_q <= 1'b1;
               if (defer_over && !defer_forever_i) begin
                  xdef_q  <= 1'b1;
                  state_q <= ST_DONE;
               end else if (!carrier_i) begin
                  state_q <= ST_SEND;
               end
            end
            ST_SEND: if (coll_i) begin
               coll_cnt_q <= cnt_nxt;
               if (late_hit) begin
                  late_q  <= 1'b1;
                  state_q <= ST_DONE;
               end else if (over_lim) begin
                  maxc_q  <= 1'b1;
                  state_q <= ST_DONE;
               end else if (immed_i)      state_q <= ST_RESUME;
               else if (no_backoff_i)     state_q <= ST_DEFER;
               else                       state_q <= ST_BACKOFF;
            end else if (tx_end_i) begin
               state_q <= ST_DONE;
            end
            ST_RESUME:  state_q <= ST_SEND;
            ST_BACKOFF: if (bo_expired) state_q <= ST_DEFER;
            ST_DONE:    state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb cnt_field = (int'(coll_cnt_q) > 15) ? 4'hF : 4'(coll_cnt_q);

   always_comb begin
      status_o = '0;
      if (state_q == ST_DONE) begin
         status_o[3:0]      = cnt_field;
         status_o[SB_MAXCOL] = maxc_q;
         status_o[SB_LATE]   = late_q;
         status_o[SB_XDEF]   = xdef_q;
         status_o[SB_DEFD]   = defd_q;
         status_o[SB_BP]     = bp_q;
         status_o[SB_ABORT]  = late_q | maxc_q | xdef_q;
         status_o[SB_OWN]    = 1'b0;
      end
   end

   assign tx_go_o = (state_q == ST_SEND);
   assign own_o   = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/hdx_retry_ctrl_chk.sv
module hdx_retry_ctrl_chk #(
   parameter int CNT_W = 11,
   parameter int WIN_W = 6,
   parameter int LIM_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             coll_i,
   input logic [CNT_W-1:0] byte_cnt_i,
   input logic [WIN_W-1:0] late_win_i,
   input logic [LIM_W-1:0] retry_lim_i,
   input logic             defer_forever_i,
   input logic             tx_go_o,
   input logic             own_o,
   input logic             done_o,
   input logic [15:0]      status_o
);
   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_handback_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!own_o && !status_o[15]));

   assert_quiet_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (status_o == 16'h0000));

   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (status_o[12:9] == 4'h0 && !status_o[6]));

   assert_start_defers_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !own_o && !done_o) |=> (own_o && !tx_go_o));

   assert_go_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go_o |-> own_o);

   assert_late_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_go_o && coll_i && byte_cnt_i >= CNT_W'(late_win_i))
      |=> (done_o && status_o[5] && status_o[14]));

   assert_coll_drops_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_go_o && coll_i) |=> !tx_go_o);

   assert_maxcoll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o[4]) |-> (status_o[14] && !status_o[5] &&
         status_o[3:0] == ((int'(retry_lim_i) >= 15) ? 4'hF : 4'(int'(retry_lim_i) + 1))));

   assert_xdef_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && status_o[7]) |-> (status_o[14] && status_o[8] && !$past(defer_forever_i)));
endmodule

bind hdx_retry_ctrl hdx_retry_ctrl_chk #(.CNT_W(CNT_W), .WIN_W(WIN_W), .LIM_W(LIM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .coll_i(coll_i),
   .byte_cnt_i(byte_cnt_i), .late_win_i(late_win_i), .retry_lim_i(retry_lim_i),
   .defer_forever_i(defer_forever_i), .tx_go_o(tx_go_o), .own_o(own_o),
   .done_o(done_o), .status_o(status_o));

// File: tb/hdx_retry_ctrl_bench.sv
module hdx_retry_ctrl_bench;
   localparam int SLN = 4;
   localparam int SLB = 8;

   logic        clk = 1'b0;
   logic        rst_n, start_i, carrier_i, coll_i, tx_end_i, tick_i, bp_i;
   logic [10:0] byte_cnt_i;
   logic        speed100_i, no_backoff_i, immed_i, defer_forever_i;
   logic [5:0]  late_win_i;
   logic [3:0]  retry_lim_i;
   logic        tx_go_o, own_o, done_o;
   logic [15:0] status_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   hdx_retry_ctrl #(.SLOT_NIB(SLN), .SLOT_BIT(SLB)) u_hdx_retry_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .carrier_i(carrier_i),
      .coll_i(coll_i), .tx_end_i(tx_end_i), .tick_i(tick_i), .byte_cnt_i(byte_cnt_i),
      .bp_i(bp_i), .speed100_i(speed100_i), .late_win_i(late_win_i),
      .retry_lim_i(retry_lim_i), .no_backoff_i(no_backoff_i), .immed_i(immed_i),
      .defer_forever_i(defer_forever_i), .tx_go_o(tx_go_o), .own_o(own_o),
      .done_o(done_o), .status_o(status_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_st(int colls, bit late, bit maxc, bit xdef,
                                          bit defd, bit bp);
      logic [15:0] s = '0;
      s[3:0] = (colls > 15) ? 4'hF : 4'(colls);
      s[4]   = maxc;
      s[5]   = late;
      s[7]   = xdef;
      s[8]   = defd;
      s[13]  = bp;
      s[14]  = late | maxc | xdef;
      return s;
   endfunction

   function automatic bit bo_ok(int d, int n, int sl);
      int e = (n > 10) ? 10 : n;
      if (d < 3) return 0;
      if ((d - 3) % sl != 0) return 0;
      return ((d - 3) / sl) <= ((1 << e) - 1);
   endfunction

   // One frame: clen = carrier-high cycles after start, ncoll collisions,
   // late_last makes the final one late, rcar = carrier hold after each collision.
   task automatic do_frame(input int clen, input int ncoll, input bit late_last,
                           input bit bpp, input bit cdef, input int rcar,
                           input int early_b, input int late_b,
                           output logic [15:0] st, output bit defd);
      int  cleft = clen;
      int  colls = 0;
      int  d = 0;
      bit  waiting = 0;
      bit  got = 0;
      bit  last_retry = 0;
      defd = (clen >= 2);
      st = '0;
      start_i   = 1'b1;
      carrier_i = (cleft > 0);
      @(negedge clk);
      start_i = 1'b0;
      chk(own_o && !tx_go_o, "R2 deferral stage after start", {own_o, tx_go_o}, 2);
      for (int cyc = 0; cyc < 40000; cyc++) begin
         coll_i = 1'b0; tx_end_i = 1'b0; bp_i = 1'b0;
         if (cleft > 0) cleft--;
         carrier_i = (cleft > 0);
         if (done_o) begin
            st  = status_o;
            got = 1;
            break;
         end
         if (waiting) begin
            d++;
            if (tx_go_o) begin
               waiting = 0;
               if (immed_i)
                  chk(d == 2, "R8 immediate retry gap", d, 2);
               else if (no_backoff_i)
                  chk(d == ((rcar + 1 > 2) ? rcar + 1 : 2), "R7 no-back-off retry gap",
                      d, (rcar + 1 > 2) ? rcar + 1 : 2);
               else
                  chk(bo_ok(d, colls, speed100_i ? SLN : SLB), "R6 back-off gap in slots", d, colls);
            end
         end
         if (tx_go_o && !waiting) begin
            if (bpp) begin bp_i = 1'b1; bpp = 0; end
            if (colls < ncoll) begin
               coll_i = 1'b1;
               if (late_last && colls == ncoll - 1)
                  byte_cnt_i = (late_b >= 0) ? 11'(late_b)
                               : 11'($urandom_range(2047, int'(late_win_i)));
               else
                  byte_cnt_i = (early_b >= 0) ? 11'(early_b)
                               : 11'($urandom_range(int'(late_win_i) - 1, 0));
               colls++;
               last_retry = !(late_last && colls == ncoll) && (colls <= int'(retry_lim_i));
               if (last_retry && !immed_i && no_backoff_i && rcar >= 2) defd = 1;
               d = 0;
               waiting = 1;
               cleft = rcar;
               carrier_i = (rcar > 0);
            end else begin
               tx_end_i = 1'b1;
            end
         end else if (cdef && carrier_i && !tx_go_o) begin
            coll_i = 1'b1;   // R12 stray collision during deferral
            cdef = 0;
         end
         @(negedge clk);
      end
      coll_i = 1'b0; tx_end_i = 1'b0; bp_i = 1'b0; carrier_i = 1'b0;
      chk(got, "R3 frame reached done", got, 1);
      @(negedge clk);
      chk(!done_o && !own_o, "R13 single-cycle done then idle", {done_o, own_o}, 0);
   endtask

   task automatic frame_chk(input string req, input int clen, input int ncoll,
                            input bit late_last, input bit bpp, input bit cdef,
                            input int rcar, input int eb, input int lb,
                            input bit xdef);
      logic [15:0] st, ex;
      bit defd;
      bit maxc;
      do_frame(clen, ncoll, late_last, bpp, cdef, rcar, eb, lb, st, defd);
      maxc = !late_last && (ncoll > int'(retry_lim_i)) && !xdef;
      ex = exp_st(xdef ? 0 : ncoll, late_last, maxc, xdef, defd, xdef ? 1'b0 : bpp);
      chk(st == ex, req, st, ex);
   endtask

   task automatic cfg(input bit spd, input int lim, input int win, input bit nob,
                      input bit imm, input bit dfv);
      speed100_i = spd; retry_lim_i = 4'(lim); late_win_i = 6'(win);
      no_backoff_i = nob; immed_i = imm; defer_forever_i = dfv;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; start_i = 0; carrier_i = 0; coll_i = 0; tx_end_i = 0;
      tick_i = 1'b1; bp_i = 0; byte_cnt_i = '0;
      cfg(1, 3, 32, 0, 0, 0);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !tx_go_o && !own_o && status_o == 0, "R1 reset state",
          {done_o, tx_go_o, own_o}, 0);

      // directed corners
      frame_chk("R3 clean frame status", 0, 0, 0, 0, 0, 0, -1, -1, 0);
      frame_chk("R2 R11 deferred with back-pressure", 10, 0, 0, 1, 0, 0, -1, -1, 0);
      frame_chk("R12 collision while deferring ignored", 10, 0, 0, 0, 1, 0, -1, -1, 0);
      cfg(1, 3, 20, 0, 0, 0);
      frame_chk("R4 byte 19 early then byte 20 late", 0, 2, 1, 0, 0, 0, 19, 20, 0);
      frame_chk("R4 early collision retried", 0, 1, 0, 0, 0, 0, 0, -1, 0);
      cfg(1, 2, 20, 1, 0, 0);
      frame_chk("R5 limit 2 aborts on third", 0, 3, 0, 0, 0, 0, -1, -1, 0);
      cfg(1, 0, 20, 1, 0, 0);
      frame_chk("R5 limit 0 aborts on first", 0, 1, 0, 0, 0, 0, -1, -1, 0);
      cfg(0, 15, 20, 1, 0, 0);
      frame_chk("R5 sixteen collisions saturate count", 0, 16, 0, 0, 0, 0, -1, -1, 0);
      cfg(1, 7, 40, 1, 0, 0);
      frame_chk("R7 no-back-off defers to carrier", 0, 2, 0, 0, 0, 6, -1, -1, 0);
      cfg(1, 7, 40, 1, 1, 0);
      frame_chk("R8 immediate ignores carrier", 0, 2, 0, 0, 0, 6, -1, -1, 0);
      cfg(0, 7, 40, 0, 0, 0);
      frame_chk("R6 back-off at 10 Mb/s", 0, 6, 0, 0, 0, 0, -1, -1, 0);
      cfg(1, 7, 40, 0, 0, 0);
      frame_chk("R6 back-off at 100 Mb/s", 0, 5, 0, 0, 0, 0, -1, -1, 0);
      frame_chk("R9 100M deferral under limit", 6000, 0, 0, 0, 0, 0, -1, -1, 0);
      frame_chk("R9 100M deferral over limit", 7000, 0, 0, 0, 0, 0, -1, -1, 1);
      cfg(0, 7, 40, 0, 0, 0);
      frame_chk("R9 10M accepts 7000 ticks", 7000, 0, 0, 0, 0, 0, -1, -1, 0);
      frame_chk("R9 10M deferral over limit", 25000, 0, 0, 0, 0, 0, -1, -1, 1);
      cfg(1, 7, 40, 0, 0, 1);
      frame_chk("R10 indefinite deferral", 8000, 0, 0, 0, 0, 0, -1, -1, 0);

      // constrained random frames
      for (int f = 0; f < 40; f++) begin
         bit nob = ($urandom_range(3, 0) == 0);
         bit imm = ($urandom_range(4, 0) == 0);
         int lim = $urandom_range(7, 0);
         int top = (lim + 1 < 6) ? lim + 1 : 6;
         int nc  = $urandom_range(top, 0);
         bit lt  = (nc > 0) && ($urandom_range(3, 0) == 0);
         int cl  = ($urandom_range(1, 0) == 1) ? $urandom_range(40, 5) : 0;
         int rc  = nob ? $urandom_range(10, 0) : 0;
         cfg(1'($urandom_range(1, 0)), lim, $urandom_range(63, 1), nob, imm, 0);
         frame_chk("R3 R4 R5 random frame status", cl, nc, lt,
                   1'($urandom_range(1, 0)), 0, rc, -1, -1, 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule